// File: doc/BRIEF.md
# Cross-Coupled Interprocessor Sync Register

This block gives two processors, called side A and side B, a small shared mailbox for handshaking. Each side sees one 16-bit register at the same offset inside its own I/O window. A side passes a 4-bit value to its partner by writing that value into its outgoing field. One write updates the writer's own register and also the partner's incoming field.

A side can also raise an interrupt on its partner. To do this it sets a one-shot trigger bit in a write. The interrupt is raised only when the partner has set its own interrupt-enable bit. Each side has a plain request/write/size/address port and one interrupt output. The interrupt output pulses for a single cycle and feeds an external interrupt controller.

Each register holds two live fields: the 4-bit incoming field in bits 3:0 and the 4-bit outgoing field in bits 11:8. It also holds the interrupt enable in bit 14. Every other bit reads back as zero.

Top module: `ipc_sync_pair`

## Requirements
- R1: After reset, both registers read 0x0000 and both interrupt outputs are low.
- R2: A valid write from one side copies bits 11:8 of the written data into bits 3:0 of the other side's register. The other side's remaining bits are unchanged.
- R3: A valid write replaces the writer's own bits 14 and 11:8 with the written bits (mask 0x4F00). The writer's bits 3:0 are kept, and all its other bits stay zero.
- R4: Bit 13 of a write is never stored. When it is set, the other side is interrupted only if that side's bit 14 was set before the write.
- R5: A 16-bit read at the register offset returns the reading side's own register. Any other read returns zero.
- R6: When both sides write in the same cycle, both sets of updates are applied. The interrupt decisions use the enable bits as they were before that cycle.
- R7: An interrupt output goes high for exactly one cycle, on the clock edge that takes the triggering write. It is low in the following cycle unless a new trigger arrives.
- R8: A write is ignored, leaving both registers unchanged and raising no interrupt, when it targets another offset or uses a size code other than 2'b01 (16-bit). The size codes are 0 for 8-bit and 2 for 32-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_req | input | 1 | Side A access strobe |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_size | input | 2 | Side A access size code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit) |
| a_addr | input | ADDR_W | Side A offset within its I/O window |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A read data (combinational) |
| a_irq | output | 1 | Interrupt pulse toward side A |
| b_req | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_size | input | 2 | Side B access size code |
| b_addr | input | ADDR_W | Side B offset within its I/O window |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B read data (combinational) |
| b_irq | output | 1 | Interrupt pulse toward side B |

## Verification
The hardest case to reach is a same-cycle collision: both sides write on one edge, one of them sets the trigger, and the write that carries the trigger is racing the partner's own write of its enable bit. The bench brings this about in three steps. First it runs a sweep that leaves a known enable state on each side. Then it issues paired writes in one cycle with every combination of the trigger and enable bits. It checks that each interrupt follows the enable value from before the edge, and that each register combines both updates.

// File: rtl/ipc_sync_pkg.sv
package ipc_sync_pkg;
  typedef logic [15:0] sync_word_t;

  localparam sync_word_t OWN_TAKE  = 16'h4F00;
  localparam sync_word_t OWN_KEEP  = 16'hB0FF & ~16'h2000;
  localparam sync_word_t PEER_KEEP = 16'hFFF0;

  localparam int TRIG_BIT = 13;
  localparam int IEN_BIT  = 14;
  localparam int OUT_LSB  = 8;
  localparam int NIB_W    = 4;

  localparam logic [1:0] SIZE_HALF = 2'b01;
  localparam int NUM_SIDES = 2;
endpackage

// File: rtl/ipc_access_decode.sv
module ipc_access_decode #(
  parameter int          ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h180
) (
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic              wr_odd
);
  import ipc_sync_pkg::*;

  logic at_reg;
  logic is_half;

  always_comb begin
    at_reg  = (addr == REG_OFFSET);
    is_half = (size == SIZE_HALF);
    wr_hit  = req & we & at_reg & is_half;
    rd_hit  = req & ~we & at_reg & is_half;
    wr_odd  = req & we & at_reg & ~is_half;
  end
endmodule

// File: rtl/ipc_sync_regs.sv
module ipc_sync_regs (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ipc_sync_pkg::NUM_SIDES-1:0]  wr_i,
  input  ipc_sync_pkg::sync_word_t            wdata_i [ipc_sync_pkg::NUM_SIDES],
  output ipc_sync_pkg::sync_word_t            regs_q  [ipc_sync_pkg::NUM_SIDES],
  output logic [ipc_sync_pkg::NUM_SIDES-1:0]  irq_q
);
  import ipc_sync_pkg::*;

  sync_word_t              regs_d [NUM_SIDES];
  logic [NUM_SIDES-1:0]    irq_d;
  logic                    regs_en;
  logic                    irq_en;

  // next state: own field first, then the partner's nibble (disjoint bits)
  always_comb begin
    for (int s = 0; s < NUM_SIDES; s++) begin
      regs_d[s] = regs_q[s];
      if (wr_i[s])
        regs_d[s] = (regs_d[s] & OWN_KEEP) | (wdata_i[s] & OWN_TAKE);
      if (wr_i[NUM_SIDES-1-s])
        regs_d[s] = (regs_d[s] & PEER_KEEP) |
                    {12'h000, wdata_i[NUM_SIDES-1-s][OUT_LSB +: NIB_W]};
      irq_d[s] = wr_i[NUM_SIDES-1-s] & wdata_i[NUM_SIDES-1-s][TRIG_BIT] &
                 regs_q[s][IEN_BIT];
    end
    regs_en = |wr_i;
    irq_en  = (|irq_d) | (|irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SIDES; s++) regs_q[s] <= '0;
    end else if (regs_en) begin
      for (int s = 0; s < NUM_SIDES; s++) regs_q[s] <= regs_d[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= '0;
    else if (irq_en) irq_q <= irq_d;
  end

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_chk
    localparam int P = NUM_SIDES - 1 - g;

    AST_PEER_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i[g] |=> regs_q[P][3:0] == $past(wdata_i[g][11:8])); // R2
    AST_OWN_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i[g] |=> (regs_q[g] & OWN_TAKE) == ($past(wdata_i[g]) & OWN_TAKE)); // R3
    AST_OWN_LOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i[g] && !wr_i[P]) |=> regs_q[g][3:0] == $past(regs_q[g][3:0])); // R3
    AST_TRIG_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      !regs_q[g][TRIG_BIT]); // R4
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q[g] |-> $past(wr_i[P] && wdata_i[P][TRIG_BIT] && regs_q[g][IEN_BIT])); // R4
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q[g] && !wr_i[P]) |=> !irq_q[g]); // R7
  end
endmodule

// File: rtl/ipc_sync_pair.sv
module ipc_sync_pair #(
  parameter int          ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [1:0]        a_size,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [15:0]       a_wdata,
  output logic [15:0]       a_rdata,
  output logic              a_irq,
  input  logic              b_req,
  input  logic              b_we,
  input  logic [1:0]        b_size,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [15:0]       b_wdata,
  output logic [15:0]       b_rdata,
  output logic              b_irq
);
  import ipc_sync_pkg::*;

  logic                 req_v  [NUM_SIDES];
  logic                 we_v   [NUM_SIDES];
  logic [1:0]           size_v [NUM_SIDES];
  logic [ADDR_W-1:0]    addr_v [NUM_SIDES];
  sync_word_t           wdat_v [NUM_SIDES];
  sync_word_t           regs   [NUM_SIDES];
  sync_word_t           rdat_v [NUM_SIDES];
  logic [NUM_SIDES-1:0] wr_hit;
  logic [NUM_SIDES-1:0] rd_hit;
  logic [NUM_SIDES-1:0] wr_odd;
  logic [NUM_SIDES-1:0] irq;

  always_comb begin
    req_v[0] = a_req;  we_v[0] = a_we;  size_v[0] = a_size;
    addr_v[0] = a_addr; wdat_v[0] = a_wdata;
    req_v[1] = b_req;  we_v[1] = b_we;  size_v[1] = b_size;
    addr_v[1] = b_addr; wdat_v[1] = b_wdata;
  end

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    ipc_access_decode #(
      .ADDR_W    (ADDR_W),
      .REG_OFFSET(REG_OFFSET)
    ) i_dec (
      .req   (req_v[g]),
      .we    (we_v[g]),
      .size  (size_v[g]),
      .addr  (addr_v[g]),
      .wr_hit(wr_hit[g]),
      .rd_hit(rd_hit[g]),
      .wr_odd(wr_odd[g])
    );

    always_comb rdat_v[g] = rd_hit[g] ? regs[g] : '0;
  end

  ipc_sync_regs i_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_hit),
    .wdata_i(wdat_v),
    .regs_q (regs),
    .irq_q  (irq)
  );

  assign a_rdata = rdat_v[0];
  assign b_rdata = rdat_v[1];
  assign a_irq   = irq[0];
  assign b_irq   = irq[1];

  AST_ODD_SIZE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_odd) && !(|wr_hit)) |=> (regs[0] == $past(regs[0]) &&
                                   regs[1] == $past(regs[1]) && !(|irq))); // R8
  AST_ONE_DIRECTION_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit[0] |-> a_rdata == 16'h0000); // R5
endmodule

// File: tb/test_ipc_sync_pair.sv
module test_ipc_sync_pair;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam logic [AW-1:0] OFF = 12'h180;

  logic clk = 1'b0;
  logic rst_n;
  logic a_req, a_we, b_req, b_we;
  logic [1:0] a_size, b_size;
  logic [AW-1:0] a_addr, b_addr;
  logic [15:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_irq, b_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] m [2];
  logic exp_irq [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_sync_pair #(.ADDR_W(AW), .REG_OFFSET(OFF)) i_ipc_sync_pair (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_we(a_we), .a_size(a_size), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_req(b_req), .b_we(b_we), .b_size(b_size), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  task automatic chk(input string rq, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, got, exp);
    end
  endtask

  task automatic idle();
    a_req = 0; a_we = 0; a_size = 2'b01; a_addr = OFF; a_wdata = 0;
    b_req = 0; b_we = 0; b_size = 2'b01; b_addr = OFF; b_wdata = 0;
  endtask

  // model update for valid writes presented together
  task automatic model(input logic wa, input logic [15:0] va,
                       input logic wb, input logic [15:0] vb);
    logic [15:0] o0, o1;
    o0 = m[0]; o1 = m[1];
    exp_irq[0] = wb & vb[13] & o0[14];
    exp_irq[1] = wa & va[13] & o1[14];
    if (wa) o0 = (o0 & 16'h90FF) | (va & 16'h4F00);
    if (wb) o1 = (o1 & 16'h90FF) | (vb & 16'h4F00);
    if (wb) o0 = (o0 & 16'hFFF0) | {12'h0, vb[11:8]};
    if (wa) o1 = (o1 & 16'hFFF0) | {12'h0, va[11:8]};
    m[0] = o0; m[1] = o1;
  endtask

  task automatic write2(input logic wa, input logic [15:0] va,
                        input logic wb, input logic [15:0] vb, input string rq);
    @(negedge clk);
    idle();
    a_req = wa; a_we = wa; a_wdata = va;
    b_req = wb; b_we = wb; b_wdata = vb;
    model(wa, va, wb, vb);
    @(posedge clk); #1;
    chk({rq, " R4 R7 irq A"}, {15'h0, a_irq}, {15'h0, exp_irq[0]});
    chk({rq, " R4 R7 irq B"}, {15'h0, b_irq}, {15'h0, exp_irq[1]});
  endtask

  task automatic read_both(input string rq);
    @(negedge clk);
    idle();
    a_req = 1; b_req = 1;
    #1;
    chk({rq, " R5 read A"}, a_rdata, m[0]);
    chk({rq, " R5 read B"}, b_rdata, m[1]);
    @(posedge clk); #1;
    chk({rq, " R7 pulse end"}, {14'h0, a_irq, b_irq}, 16'h0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    m[0] = 0; m[1] = 0;
    #(CLK_PERIOD * 3);
    @(negedge clk) rst_n = 1;
    #1;
    chk("R1 irq after reset", {14'h0, a_irq, b_irq}, 16'h0);
    read_both("R1");

    // sweep: each side, all nibble/trigger/enable combos, with junk bits
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 128; v++) begin
        logic [15:0] w;
        w = {1'b0, v[5], v[4], 1'b0, v[3:0], 8'h00};
        if (v[6]) w = w | 16'h90A5;
        if (s == 0) write2(1, w, 0, 16'h0, "R2 R3 sweep A");
        else        write2(0, 16'h0, 1, w, "R2 R3 sweep B");
        read_both("R2 R3 R4 sweep");
      end
    end

    // simultaneous writes, all trigger/enable combos (R6)
    for (int k = 0; k < 64; k++) begin
      logic [15:0] va, vb;
      va = {1'b0, k[0], k[1], 1'b0, k[5:2], 8'h3C};
      vb = {1'b1, k[2], k[3], 1'b1, k[3:0] ^ 4'hA, 8'h00};
      write2(1, va, 1, vb, "R6 both");
      read_both("R6 both");
    end

    // set both enables, then odd-size and wrong-offset writes (R8)
    write2(1, 16'h4500, 1, 16'h4A00, "R8 setup");
    read_both("R8 setup");
    for (int sz = 0; sz < 4; sz++) begin
      for (int t = 0; t < 2; t++) begin
        @(negedge clk);
        idle();
        a_req = 1; a_we = 1; a_wdata = 16'h6F00;
        b_req = 1; b_we = 1; b_wdata = 16'h2F00;
        if (t == 0) begin a_addr = OFF + 12'h4; b_addr = OFF - 12'h2; end
        else if (sz == 1) begin a_req = 0; b_req = 0; end
        else begin a_size = 2'(sz); b_size = 2'(sz); end
        @(posedge clk); #1;
        chk("R8 no irq", {14'h0, a_irq, b_irq}, 16'h0);
        // odd-size / wrong-offset reads give zero (R5)
        @(negedge clk);
        idle();
        a_req = 1; b_req = 1;
        if (t == 0) begin a_addr = OFF + 12'h2; b_addr = OFF + 12'h2; end
        else if (sz != 1) begin a_size = 2'(sz); b_size = 2'(sz); end
        else begin a_req = 0; b_req = 0; end
        #1;
        chk("R5 odd read A", a_rdata, 16'h0);
        chk("R5 odd read B", b_rdata, 16'h0);
        read_both("R8 unchanged");
      end
    end

    // trigger into enabled side, back to back pulses then end (R7)
    write2(1, 16'h2000, 0, 16'h0, "R7 first");
    write2(1, 16'h2000, 0, 16'h0, "R7 second");
    read_both("R7 after");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule